// File: doc/BRIEF.md
# UART Baud Strobe Generator with Selectable Prescaler

This block turns a reference clock into the 16x oversampling strobe used by one UART channel. It does not make a new clock. It produces a one-cycle enable pulse, `baud_tick`, in the reference clock domain. The transmitter uses this pulse to shift bits and the receiver uses it to sample. Each channel gets its own instance.

Division happens in two stages.

- **Prescaler.** It divides the reference by 1 or by 4. The ratio selector picks the source of that choice.
  - It starts in state PIN. Here the ratio follows the level of `pre4_pin` as captured during reset.
  - The first software write moves it to state SOFT. SOFT then holds until the next reset. In SOFT, each write to `mode_we` replaces the ratio with `mode_pre4`.
  - Reset always returns the selector to PIN.
- **Divisor counter.** It counts prescaler pulses against a 16-bit divisor that is written one byte at a time. It has three states:
  - HALT: the divisor is zero.
  - RELOAD: a one-cycle quiet state entered on every restart.
  - RUN: counting.
  - Transitions:
    - HALT→RELOAD when a restart occurs.
    - RELOAD→RUN when the divisor is non-zero.
    - RELOAD→HALT when the divisor is zero.
    - RELOAD→RELOAD on a further restart.
    - RUN→RELOAD when a restart occurs.

A restart is caused by either of two events: a write to either divisor byte, or a mode write that changes the effective ratio.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is high, and after reset until a non-zero divisor is written, `baud_tick` stays low.
- R2: A divisor value of 0 halts the generator, and no strobe is produced.
- R3: With ratio 1 and divisor N > 1, `baud_tick` is high for exactly one cycle in every N cycles. The first strobe comes N+1 cycles after the last restarting write cycle.
- R4: With ratio 1 and divisor 1, `baud_tick` is high on every cycle of RUN.
- R5: With ratio 4 and divisor N, the strobe period is 4N cycles. The first strobe comes 4N+1 cycles after the restarting write cycle.
- R6: The ratio is set to 4 when `pre4_pin` is 1 in the last reset cycle and to 1 when it is 0. Changing the pin after reset has no effect.
- R7: A cycle with `mode_we` high sets the ratio to 4 if `mode_pre4` is 1 and to 1 if it is 0. This choice overrides the pin and holds until the next reset.
- R8: Reset discards the software override, so the ratio again follows the pin captured during reset.
- R9: A divisor write suppresses the strobe in its own cycle and in the next cycle. Counting then restarts from zero with the prescaler phase cleared.
- R10: `div_wdata` is loaded into bits 7:0 of the divisor by `div_lo_we` and into bits 15:8 by `div_hi_we`. Bytes that are not written keep their value.
- R11: A mode write that changes the ratio restarts the counter in the same way as a divisor write. A mode write that leaves the ratio unchanged does not disturb the strobe train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high; `pre4_pin` is captured while it is high |
| pre4_pin | input | 1 | Hardware ratio select: 1 selects divide-by-4 |
| mode_we | input | 1 | Software ratio write strobe |
| mode_pre4 | input | 1 | Software ratio value: 1 selects divide-by-4 |
| div_lo_we | input | 1 | Write strobe for divisor bits 7:0 |
| div_hi_we | input | 1 | Write strobe for divisor bits 15:8 |
| div_wdata | input | 8 | Divisor byte data |
| baud_tick | output | 1 | One-cycle 16x oversampling strobe |

## Verification
The main function is tried with four kinds of pattern:

- **Ratio 1, divisor 5 and 3.** This separates a correct period from off-by-one reload errors.
- **Divisor 1.** This shows whether the counter can fire back-to-back.
- **Ratio 4, divisor 1 and 3.** This tells whether the prescaler multiplies the period rather than adding to it.
- **16-bit divisor 0x0102.** This exposes a high byte that is swapped or dropped.

The ratio is also exercised through every path that sets it:

- A pin level that changes after reset.
- Mode writes that change the ratio and mode writes that leave it unchanged.
- A reset that follows a software override.

A divisor rewrite placed exactly on a pending strobe shows whether a stale pulse leaks out.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        GEN_HALT   = 2'd0,
        GEN_RELOAD = 2'd1,
        GEN_RUN    = 2'd2
    } gen_state_e;

    typedef enum logic {
        SRC_PIN  = 1'b0,
        SRC_SOFT = 1'b1
    } ratio_src_e;

endpackage

// File: rtl/baud_ratio_sel.sv
module baud_ratio_sel
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_pin,
    input  logic ctl_we,
    input  logic ctl_val,
    output logic div4_o,
    output logic change_o
);

    ratio_src_e src_q;
    ratio_src_e src_d;
    logic       pin_q;
    logic       soft_q;

    // next-state logic: PIN -> SOFT on the first software write, SOFT holds
    always_comb begin
        src_d = src_q;
        unique case (src_q)
            SRC_PIN:  if (ctl_we) src_d = SRC_SOFT;
            SRC_SOFT: src_d = SRC_SOFT;
            default:  src_d = SRC_PIN;
        endcase
    end

    // state register; the pin is tracked only while reset is high
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_PIN;
            pin_q  <= sel_pin;
            soft_q <= 1'b0;
        end else begin
            src_q <= src_d;
            if (ctl_we) begin
                soft_q <= ctl_val;
            end
        end
    end

    // outputs
    always_comb begin
        div4_o   = (src_q == SRC_SOFT) ? soft_q : pin_q;
        change_o = ctl_we && (ctl_val != div4_o);
    end

    // R6: after reset the ratio only moves on a software write
    a_r6_pin_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl_we)) |-> $stable(div4_o));

    // R8: leaving reset, the ratio equals the pin seen in the last reset cycle
    a_r8_pin_capture: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (div4_o == $past(sel_pin)));

    // R7: a software write decides the ratio from the next cycle
    a_r7_soft_follow: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (div4_o == $past(ctl_val)));

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic div4,
    input  logic hold,
    output logic pre_en
);

    localparam int PC_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(RATIO - 1);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst || hold || !div4) begin
            pc_q <= '0;
        end else if (pc_q == PC_LAST) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PC_W'(1);
        end
    end

    always_comb begin
        pre_en = div4 ? (pc_q == PC_LAST) : 1'b1;
    end

    // R5: in divide mode two prescaler pulses are never adjacent
    a_r5_pre_gap: assert property (@(posedge clk) disable iff (rst)
        ((RATIO > 1) && div4 && $past(div4) && $past(pre_en)) |-> !pre_en);

endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          byte_we,
    input  logic [DIV_W/2-1:0]  wdata,
    output logic [DIV_W-1:0]    divisor,
    output logic                wr_any
);

    localparam int BYTE_W = DIV_W / 2;
    localparam int NB     = 2;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (byte_we[b]) begin
                byte_q <= wdata;
            end
        end

        assign divisor[b*BYTE_W +: BYTE_W] = byte_q;

        // R10: a written byte lands in its own slice of the divisor
        a_r10_byte_load: assert property (@(posedge clk) disable iff (rst)
            byte_we[b] |=> (divisor[b*BYTE_W +: BYTE_W] == $past(wdata)));
    end

    assign wr_any = |byte_we;

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             pre_en,
    input  logic [DIV_W-1:0] divisor,
    output logic             hold_pre,
    output logic             tick
);

    gen_state_e       state_q;
    gen_state_e       state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == (divisor - DIV_W'(1)));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_HALT: begin
                if (restart) state_d = GEN_RELOAD;
            end
            GEN_RELOAD: begin
                if (restart)              state_d = GEN_RELOAD;
                else if (divisor == '0)   state_d = GEN_HALT;
                else                      state_d = GEN_RUN;
            end
            GEN_RUN: begin
                if (restart) state_d = GEN_RELOAD;
            end
            default: state_d = GEN_HALT;
        endcase
    end

    // state register and count
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q != GEN_RUN) || restart) begin
                cnt_q <= '0;
            end else if (pre_en) begin
                cnt_q <= at_last ? '0 : (cnt_q + DIV_W'(1));
            end
        end
    end

    // outputs
    always_comb begin
        hold_pre = (state_q != GEN_RUN);
        tick     = (state_q == GEN_RUN) && !restart && !rst && pre_en && at_last;
    end

    // R3: the count never reaches the divisor while running
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == GEN_RUN) |-> (cnt_q < divisor));

    // R3: only a divisor of one can fire on consecutive cycles
    a_r3_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (tick && (divisor != DIV_W'(1))) |=> !tick);

    // R9: the cycle after a restart is quiet
    a_r9_reload_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> !tick);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int PRE_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pre4_pin,
    input  logic               mode_we,
    input  logic               mode_pre4,
    input  logic               div_lo_we,
    input  logic               div_hi_we,
    input  logic [DIV_W/2-1:0] div_wdata,
    output logic               baud_tick
);

    logic             div4;
    logic             ratio_chg;
    logic             pre_en;
    logic             hold_pre;
    logic [DIV_W-1:0] divisor;
    logic             div_wr;
    logic             restart;

    baud_ratio_sel u_ratio (
        .clk      (clk),
        .rst      (rst),
        .sel_pin  (pre4_pin),
        .ctl_we   (mode_we),
        .ctl_val  (mode_pre4),
        .div4_o   (div4),
        .change_o (ratio_chg)
    );

    baud_div_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .byte_we ({div_hi_we, div_lo_we}),
        .wdata   (div_wdata),
        .divisor (divisor),
        .wr_any  (div_wr)
    );

    assign restart = div_wr || ratio_chg;

    baud_prescaler #(.RATIO(PRE_RATIO)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .div4   (div4),
        .hold   (hold_pre),
        .pre_en (pre_en)
    );

    baud_div_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .pre_en   (pre_en),
        .divisor  (divisor),
        .hold_pre (hold_pre),
        .tick     (baud_tick)
    );

    // R1: no strobe while reset is high
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> !baud_tick);

    // R2: a zero divisor never produces a strobe
    a_r2_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (divisor == '0) |-> !baud_tick);

    // R9: the write cycle itself never carries a strobe
    a_r9_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (div_lo_we || div_hi_we) |-> !baud_tick);

endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre4_pin = 1'b0;
    logic       mode_we = 1'b0;
    logic       mode_pre4 = 1'b0;
    logic       div_lo_we = 1'b0;
    logic       div_hi_we = 1'b0;
    logic [7:0] div_wdata = 8'h00;
    logic       baud_tick;

    baud_tick_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .pre4_pin  (pre4_pin),
        .mode_we   (mode_we),
        .mode_pre4 (mode_pre4),
        .div_lo_we (div_lo_we),
        .div_hi_we (div_hi_we),
        .div_wdata (div_wdata),
        .baud_tick (baud_tick)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    t;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    cur_n = 0;
    bit    cur_div4 = 1'b0;
    int    cur_p = 0;
    int    next_t = 0;

    // monitor: compares observed strobes against the expected queue
    always @(negedge clk) begin
        if (!done) begin
            while (exp_q.size() > 0 && exp_q[0].t < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s missed strobe: actual none, expected cycle %0d",
                         exp_q[0].req, exp_q[0].t);
                void'(exp_q.pop_front());
            end
            if (baud_tick) begin
                checks++;
                if (exp_q.size() > 0 && exp_q[0].t == cyc) begin
                    void'(exp_q.pop_front());
                end else begin
                    errors++;
                    $display("FAIL %s unexpected strobe: actual cycle %0d, expected cycle %0d",
                             cur_req, cyc, (exp_q.size() > 0) ? exp_q[0].t : -1);
                end
            end
        end
    end

    task automatic restart_model(int r);
        cur_p = cur_n * (cur_div4 ? 4 : 1);
        if (cur_p != 0) next_t = r + cur_p - 1;
    endtask

    task automatic advance(int e);
        while (cur_p != 0 && next_t <= e) begin
            exp_q.push_back('{t: next_t, req: cur_req});
            next_t += cur_p;
        end
        while (cyc < e) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_div(int n);
        int w;
        @(posedge clk); #1;
        div_lo_we = 1'b1;
        div_wdata = n[7:0];
        @(posedge clk); #1;
        div_lo_we = 1'b0;
        div_hi_we = 1'b1;
        div_wdata = n[15:8];
        w = cyc;
        @(posedge clk); #1;
        div_hi_we = 1'b0;
        cur_n = n;
        restart_model(w + 2);
    endtask

    task automatic wr_lo(int v);
        int w;
        @(posedge clk); #1;
        div_lo_we = 1'b1;
        div_wdata = v[7:0];
        w = cyc;
        @(posedge clk); #1;
        div_lo_we = 1'b0;
        cur_n = (cur_n & 32'hFF00) | (v & 32'hFF);
        restart_model(w + 2);
    endtask

    task automatic wr_mode(bit v);
        int w;
        @(posedge clk); #1;
        mode_we = 1'b1;
        mode_pre4 = v;
        w = cyc;
        @(posedge clk); #1;
        mode_we = 1'b0;
        if (v != cur_div4) begin
            cur_div4 = v;
            restart_model(w + 2);
        end
    endtask

    task automatic quiet(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (baud_tick !== 1'b0) begin
                errors++;
                $display("FAIL %s strobe while idle: actual %b, expected 0 at cycle %0d",
                         req, baud_tick, cyc);
            end
        end
    endtask

    task automatic do_reset(bit pin, int len);
        @(posedge clk); #1;
        rst = 1'b1;
        pre4_pin = pin;
        cur_p = 0;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
        end
        rst = 1'b0;
        cur_div4 = pin;
        cur_n = 0;
    endtask

    initial begin
        // R1: reset with pin low, then idle with no divisor
        cur_req = "R1";
        quiet(5, "R1");
        @(posedge clk); #1;
        rst = 1'b0;
        quiet(20, "R1");

        // R3: ratio 1, divisor 5
        cur_req = "R3";
        wr_div(5);
        advance(cyc + 60);

        // R6: pin changes after reset; period keeps ratio 1
        cur_req = "R6";
        wr_div(3);
        advance(cyc + 10);
        pre4_pin = 1'b1;
        advance(cyc + 40);

        // R4: divisor 1 at ratio 1 strobes every cycle
        cur_req = "R4";
        wr_div(1);
        advance(cyc + 20);

        // R7: software selects divide-by-4
        cur_req = "R7";
        wr_mode(1'b1);
        advance(cyc + 30);

        // R5: ratio 4 with divisor 3 gives period 12
        cur_req = "R5";
        wr_div(3);
        advance(cyc + 60);

        // R11: unchanged mode write keeps the train, changed one restarts it
        cur_req = "R11";
        wr_mode(1'b1);
        advance(cyc + 40);
        wr_mode(1'b0);
        advance(cyc + 30);

        // R9: rewrite lands on a pending strobe, which must vanish
        cur_req = "R9";
        advance(next_t - 1);
        wr_lo(3);
        advance(cyc + 30);

        // R10: full 16-bit divisor 0x0102 = 258
        cur_req = "R10";
        wr_div(16'h0102);
        advance(cyc + 600);

        // R2: divisor 0 halts
        cur_req = "R2";
        wr_div(0);
        quiet(80, "R2");

        // R8: override at ratio 1, reset with pin high gives ratio 4
        cur_req = "R8";
        wr_div(2);
        advance(cyc + 20);
        do_reset(1'b1, 4);
        quiet(10, "R8");
        wr_div(2);
        advance(cyc + 60);

        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3 pending strobes at end: actual %0d, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual hung at cycle %0d, expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule